// File: doc/BRIEF.md
# Machine-Cycle Sequencer

This block is the timing and state controller for a small 8-bit processor core. It divides the input clock into machine cycles and decides which kind of cycle comes next: instruction fetch, execute, DMA service or interrupt response. The cycle type depends on requests sampled at cycle boundaries and on hints from the instruction decoder. The datapath, register file, decoder and memory sit outside this block. They watch the two-bit state code and the pulse counter to time their own work.

Two mode-select lines choose between reset, pause and run. Reset parks the sequencer in a known execute-coded state. The first cycle after reset is a longer initialization cycle. Pause freezes the timing generator exactly where it stands, and run resumes from that point. All sequencing registers update on the falling edge of the clock.

Top module: `cycle_sequencer`

## Requirements
- R1: In run mode, every machine cycle other than the initialization cycle lasts CYCLE_PULSES (default 8) falling clock edges. The pulse counter runs from 0 to CYCLE_PULSES-1. `cycle_end` is high while the counter holds the last pulse of the current cycle. The state code is 0 for fetch, 1 for execute, 2 for DMA service and 3 for interrupt response.
- R2: The first cycle after leaving reset is an initialization cycle. It carries state code 1 and lasts CYCLE_PULSES+INIT_EXTRA (default 9) edges. It is followed by DMA service (2) if either DMA request is high at its end, and by fetch (0) otherwise.
- R3: An interrupt request is never honoured at the end of the initialization cycle, even when it is enabled.
- R4: Fetch is always followed by execute, whatever requests are pending. At the end of the first execute cycle of an instruction, a high `long_hint` forces one more execute cycle, overriding every request. A third execute cycle is never forced.
- R5: At the end of an execute, DMA or interrupt cycle, a DMA request on either line selects DMA service. Otherwise an interrupt request with `irq_en` high selects interrupt response. Otherwise the next cycle is fetch. An interrupt request with `irq_en` low has no effect.
- R6: At the end of a non-forced execute cycle with `idle_hint` high and nothing serviceable pending, the next cycle is again execute. The loop ends when a DMA request or an enabled interrupt arrives.
- R7: `ie_clear` is high during exactly the first pulse of each interrupt-response cycle and low at every other time. After an interrupt-response cycle the next cycle is fetch, unless a DMA request is pending.
- R8: `mode_sel` = 2 (pause) holds the state code and pulse counter unchanged from the first falling edge on. `mode_sel` = 3 (run) continues the interrupted cycle from the held count.
- R9: `mode_sel` = 0 or 1 (reset) forces state code 1 and pulse count 0, with `cycle_end` and `ie_clear` low. All requests and hints are ignored while reset is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the sequencer acts on its falling edge |
| mode_sel | input | 2 | 0/1 reset, 2 pause, 3 run |
| dma_in_req | input | 1 | DMA request, inbound direction |
| dma_out_req | input | 1 | DMA request, outbound direction |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt-enable flag from the datapath |
| long_hint | input | 1 | Decoder: instruction needs a second execute cycle |
| idle_hint | input | 1 | Decoder: current instruction is the idle instruction |
| state_code | output | 2 | Current machine state (0 fetch, 1 execute, 2 DMA, 3 interrupt) |
| pulse_cnt | output | CNT_W | Pulse index within the current cycle |
| cycle_end | output | 1 | High on the last pulse of the current cycle |
| ie_clear | output | 1 | One-pulse request to clear the interrupt-enable flag |

## Verification
The state code changes on the falling edge that ends a cycle. The bench therefore drives inputs just after a rising edge and samples just after the next rising edges. The new state is read one rising edge after the falling edge that closes the cycle: the ninth rising edge for the initialization cycle and the eighth otherwise. `cycle_end` is read one rising edge earlier, while the last pulse is still held. `ie_clear` is combinational-free and registered on the boundary edge itself, so it is checked at the same sample as the new state and again one full cycle later, when it must be low. The pause test counts rising edges from the pause request, expects the counter to be frozen at the value sampled when pause was selected, and then expects the boundary exactly the remaining number of edges after run returns.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;
   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EXEC  = 2'd1,
      ST_DMA   = 2'd2,
      ST_INTR  = 2'd3
   } mstate_t;

   typedef enum logic [1:0] {
      MD_RST0 = 2'd0,
      MD_RST1 = 2'd1,
      MD_HOLD = 2'd2,
      MD_RUN  = 2'd3
   } mode_t;

   function automatic logic mode_is_reset(input logic [1:0] m);
      return (m == MD_RST0) || (m == MD_RST1);
   endfunction
endpackage

// File: rtl/pulse_timer.sv
module pulse_timer #(
   parameter int CYCLE_PULSES = 8,
   parameter int INIT_EXTRA   = 1,
   localparam int CNT_W       = $clog2(CYCLE_PULSES + INIT_EXTRA)
) (
   input  logic             clk,
   input  logic             clear,
   input  logic             advance,
   input  logic             init_cyc,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(CYCLE_PULSES - 1);
   localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(CYCLE_PULSES + INIT_EXTRA - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (INIT_EXTRA == 0) begin : g_flat
         assign last = (cnt_q == NORM_LAST);
      end else begin : g_long_init
         assign last = init_cyc ? (cnt_q == INIT_LAST) : (cnt_q == NORM_LAST);
      end
   endgenerate

   always_ff @(negedge clk) begin
      if (clear)
         cnt_q <= '0;
      else if (advance)
         cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/next_state_logic.sv
module next_state_logic
   import cyc_seq_pkg::*;
(
   input  mstate_t cur,
   input  logic    init_cyc,
   input  logic    second_exec,
   input  logic    dma_pend,
   input  logic    irq_pend,
   input  logic    irq_en,
   input  logic    long_hint,
   input  logic    idle_hint,
   output mstate_t nxt,
   output logic    force_second
);
   logic    irq_ok;
   mstate_t serviced;

   assign irq_ok = irq_pend && irq_en;

   always_comb begin
      if (dma_pend)
         serviced = ST_DMA;
      else if (irq_ok)
         serviced = ST_INTR;
      else
         serviced = ST_FETCH;
   end

   always_comb begin
      nxt          = ST_FETCH;
      force_second = 1'b0;
      if (init_cyc) begin
         nxt = dma_pend ? ST_DMA : ST_FETCH;
      end else begin
         unique case (cur)
            ST_FETCH: nxt = ST_EXEC;
            ST_EXEC: begin
               if (!second_exec && long_hint) begin
                  nxt          = ST_EXEC;
                  force_second = 1'b1;
               end else if (idle_hint && !dma_pend && !irq_ok) begin
                  nxt = ST_EXEC;
               end else begin
                  nxt = serviced;
               end
            end
            ST_DMA:  nxt = serviced;
            ST_INTR: nxt = dma_pend ? ST_DMA : ST_FETCH;
            default: nxt = ST_FETCH;
         endcase
      end
   end
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
   import cyc_seq_pkg::*;
#(
   parameter int CYCLE_PULSES = 8,
   parameter int INIT_EXTRA   = 1,
   localparam int CNT_W       = $clog2(CYCLE_PULSES + INIT_EXTRA)
) (
   input  logic             clk,
   input  logic [1:0]       mode_sel,
   input  logic             dma_in_req,
   input  logic             dma_out_req,
   input  logic             irq_req,
   input  logic             irq_en,
   input  logic             long_hint,
   input  logic             idle_hint,
   output logic [1:0]       state_code,
   output logic [CNT_W-1:0] pulse_cnt,
   output logic             cycle_end,
   output logic             ie_clear
);
   generate
      if (CYCLE_PULSES < 2) begin : g_bad_len
         $error("CYCLE_PULSES must be at least 2");
      end
      if (INIT_EXTRA < 0) begin : g_bad_extra
         $error("INIT_EXTRA must not be negative");
      end
   endgenerate

   logic    in_reset, running, last_pulse, boundary;
   logic    init_q, second_q, ie_clr_q, force_second;
   mstate_t state_q, nxt_state;

   assign in_reset = mode_is_reset(mode_sel);
   assign running  = (mode_sel == MD_RUN);
   assign boundary = running && last_pulse;

   pulse_timer #(
      .CYCLE_PULSES(CYCLE_PULSES),
      .INIT_EXTRA  (INIT_EXTRA)
   ) u_timer (
      .clk     (clk),
      .clear   (in_reset),
      .advance (running),
      .init_cyc(init_q),
      .cnt     (pulse_cnt),
      .last    (last_pulse)
   );

   next_state_logic u_next (
      .cur         (state_q),
      .init_cyc    (init_q),
      .second_exec (second_q),
      .dma_pend    (dma_in_req || dma_out_req),
      .irq_pend    (irq_req),
      .irq_en      (irq_en),
      .long_hint   (long_hint),
      .idle_hint   (idle_hint),
      .nxt         (nxt_state),
      .force_second(force_second)
   );

   always_ff @(negedge clk) begin
      if (in_reset) begin
         state_q  <= ST_EXEC;
         init_q   <= 1'b1;
         second_q <= 1'b0;
         ie_clr_q <= 1'b0;
      end else if (boundary) begin
         state_q  <= nxt_state;
         init_q   <= 1'b0;
         second_q <= force_second;
         ie_clr_q <= (nxt_state == ST_INTR);
      end else begin
         ie_clr_q <= 1'b0;
      end
   end

   assign state_code = state_q;
   assign cycle_end  = boundary;
   assign ie_clear   = ie_clr_q;
endmodule

// File: rtl/cycle_sequencer_chk.sv
module cycle_sequencer_chk #(
   parameter int CYCLE_PULSES = 8,
   parameter int INIT_EXTRA   = 1,
   localparam int CNT_W       = $clog2(CYCLE_PULSES + INIT_EXTRA)
) (
   input logic             clk,
   input logic [1:0]       mode_sel,
   input logic             dma_in_req,
   input logic             dma_out_req,
   input logic [1:0]       state_code,
   input logic [CNT_W-1:0] pulse_cnt,
   input logic             cycle_end,
   input logic             ie_clear
);
   logic seen_rst = 1'b0;
   logic rst_mode, run_mode, hold_mode, dma_any;

   assign rst_mode  = (mode_sel[1] == 1'b0);
   assign run_mode  = (mode_sel == 2'd3);
   assign hold_mode = (mode_sel == 2'd2);
   assign dma_any   = dma_in_req || dma_out_req;

   always_ff @(negedge clk) begin
      if (rst_mode) seen_rst <= 1'b1;
   end

   AST_CNT_RANGE: assert property (@(negedge clk) disable iff (!seen_rst || rst_mode)
      pulse_cnt <= CNT_W'(CYCLE_PULSES + INIT_EXTRA - 1));  // R1

   AST_RESET_HOLD: assert property (@(negedge clk) disable iff (!seen_rst)
      rst_mode |=> (state_code == 2'd1 && pulse_cnt == '0 && !ie_clear));  // R9

   AST_INIT_NO_INT: assert property (@(negedge clk) disable iff (!seen_rst || rst_mode)
      (run_mode && cycle_end && pulse_cnt >= CNT_W'(CYCLE_PULSES)) |=> state_code != 2'd3);  // R3

   AST_FETCH_TO_EXEC: assert property (@(negedge clk) disable iff (!seen_rst || rst_mode)
      (run_mode && cycle_end && state_code == 2'd0 && pulse_cnt == CNT_W'(CYCLE_PULSES - 1))
      |=> state_code == 2'd1);  // R4

   AST_DMA_FIRST: assert property (@(negedge clk) disable iff (!seen_rst || rst_mode)
      (run_mode && cycle_end && state_code[1] && dma_any) |=> state_code == 2'd2);  // R5

   AST_IE_CLR_PULSE: assert property (@(negedge clk) disable iff (!seen_rst || rst_mode)
      ie_clear |-> (state_code == 2'd3 && pulse_cnt == '0));  // R7

   AST_PAUSE_FREEZE: assert property (@(negedge clk) disable iff (!seen_rst || rst_mode)
      hold_mode |=> ($stable(state_code) && $stable(pulse_cnt)));  // R8
endmodule

bind cycle_sequencer cycle_sequencer_chk #(
   .CYCLE_PULSES(CYCLE_PULSES),
   .INIT_EXTRA  (INIT_EXTRA)
) chk_i (
   .clk        (clk),
   .mode_sel   (mode_sel),
   .dma_in_req (dma_in_req),
   .dma_out_req(dma_out_req),
   .state_code (state_code),
   .pulse_cnt  (pulse_cnt),
   .cycle_end  (cycle_end),
   .ie_clear   (ie_clear)
);

// File: tb/cycle_sequencer_tb_top.sv
module cycle_sequencer_tb_top;
   localparam int CNT_W = 4;
   localparam int NV    = 16;
   // vector: [11:8] requirement, [7:6] expected state,
   // [5] dma_in [4] dma_out [3] irq [2] irq_en [1] long [0] idle
   localparam logic [11:0] VEC [NV] = '{
      {4'd4, 2'd1, 6'b101100}, // R4 fetch ignores requests
      {4'd4, 2'd1, 6'b100010}, // R4 forced second execute beats DMA
      {4'd4, 2'd0, 6'b000010}, // R4 no third execute
      {4'd4, 2'd1, 6'b000000}, // R4 fetch -> execute
      {4'd5, 2'd2, 6'b101100}, // R5 DMA beats interrupt
      {4'd5, 2'd2, 6'b010000}, // R5 DMA after DMA
      {4'd5, 2'd3, 6'b001100}, // R5 enabled interrupt
      {4'd7, 2'd0, 6'b001100}, // R7 after interrupt -> fetch
      {4'd4, 2'd1, 6'b000000}, // R4
      {4'd6, 2'd1, 6'b000001}, // R6 idle loop holds
      {4'd6, 2'd1, 6'b001001}, // R6 disabled interrupt keeps idling
      {4'd6, 2'd3, 6'b001101}, // R6 enabled interrupt ends idle
      {4'd7, 2'd2, 6'b010000}, // R7 after interrupt -> DMA
      {4'd5, 2'd0, 6'b000000}, // R5 nothing pending -> fetch
      {4'd4, 2'd1, 6'b000000}, // R4
      {4'd5, 2'd0, 6'b001000}  // R5 interrupt without enable ignored
   };

   logic             clk = 1'b0;
   logic [1:0]       mode_sel = 2'd0;
   logic             dma_in_req = 1'b0, dma_out_req = 1'b0, irq_req = 1'b0;
   logic             irq_en = 1'b0, long_hint = 1'b0, idle_hint = 1'b0;
   logic [1:0]       state_code;
   logic [CNT_W-1:0] pulse_cnt;
   logic             cycle_end, ie_clear;
   int               n_checks = 0, n_fail = 0;

   always #5 clk = ~clk;

   cycle_sequencer dut_i (
      .clk(clk), .mode_sel(mode_sel), .dma_in_req(dma_in_req),
      .dma_out_req(dma_out_req), .irq_req(irq_req), .irq_en(irq_en),
      .long_hint(long_hint), .idle_hint(idle_hint), .state_code(state_code),
      .pulse_cnt(pulse_cnt), .cycle_end(cycle_end), .ie_clear(ie_clear)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] v);
      {dma_in_req, dma_out_req, irq_req, irq_en, long_hint, idle_hint} = v;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // runs len rising edges; boundary strobe due at len-1, new state at len
   task automatic step_cycle(input int len, input int exp_state, input string tag);
      repeat (len - 1) @(posedge clk);
      #1;
      check({tag, " cycle_end on last pulse (R1)"}, int'(cycle_end), 1);
      check({tag, " ie_clear low mid-cycle (R7)"}, int'(ie_clear), 0);
      @(posedge clk);
      #1;
      check({tag, " next state"}, int'(state_code), exp_state);
      check({tag, " count restarts (R1)"}, int'(pulse_cnt), 0);
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R9: reset with every request and hint asserted
      drive(6'b111111);
      repeat (4) @(posedge clk);
      #1;
      check("R9 state", int'(state_code), 1);
      check("R9 count", int'(pulse_cnt), 0);
      check("R9 ie_clear", int'(ie_clear), 0);
      check("R9 cycle_end", int'(cycle_end), 0);

      // R2/R3: nine-pulse init, enabled interrupt not taken
      drive(6'b001100);
      mode_sel = 2'd3;
      repeat (8) @(posedge clk);
      #1;
      check("R2 init still executing", int'(state_code), 1);
      check("R2 init count", int'(pulse_cnt), 8);
      check("R2 init strobe", int'(cycle_end), 1);
      @(posedge clk);
      #1;
      check("R3 init then fetch", int'(state_code), 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][5:0]);
         step_cycle(8, int'(VEC[i][7:6]), $sformatf("R%0d vec%0d", VEC[i][11:8], i));
         check($sformatf("R7 ie_clear vec%0d", i), int'(ie_clear), int'(VEC[i][7:6] == 2'd3));
      end

      // R8: pause mid-fetch, then resume
      drive(6'b000000);
      repeat (3) @(posedge clk);
      #1;
      check("R8 count before pause", int'(pulse_cnt), 3);
      mode_sel = 2'd2;
      drive(6'b111100);
      repeat (6) @(posedge clk);
      #1;
      check("R8 frozen count", int'(pulse_cnt), 3);
      check("R8 frozen state", int'(state_code), 0);
      check("R8 no strobe in pause", int'(cycle_end), 0);
      drive(6'b000000);
      mode_sel = 2'd3;
      step_cycle(5, 1, "R8 resume");

      // R9: reset mid-cycle, requests ignored; R2: init then DMA
      repeat (2) @(posedge clk);
      #1;
      drive(6'b111111);
      mode_sel = 2'd0;
      repeat (2) @(posedge clk);
      #1;
      check("R9 mid-cycle reset state", int'(state_code), 1);
      check("R9 mid-cycle reset count", int'(pulse_cnt), 0);
      drive(6'b101100);
      mode_sel = 2'd3;
      step_cycle(9, 2, "R2 init then DMA");
      drive(6'b001100);
      step_cycle(8, 3, "R5 DMA then interrupt");
      check("R7 ie_clear on entry", int'(ie_clear), 1);
      finish_run();
   end
endmodule